// File: doc/BRIEF.md
# Serial Converter Read Master

This block is the host side of a link to an 8-bit serial successive-approximation converter. A single-cycle request carries a channel number, a single-ended/differential choice and an echo enable. The block pulls chip select low and generates the serial clock from the system clock. It shifts out a start bit and the multiplexer address, lets one converter clock pass for multiplexer settling, and then collects the result most significant bit first. When the echo is enabled, the converter also sends the result again least significant bit first. The block collects that copy and compares it with the first one.

The result appears with a one-cycle valid strobe. A mismatch flag accompanies the strobe when the echoed copy disagrees. Both half-periods of the serial clock are set by a parameter in system clock cycles. Elaboration rejects any value that puts a half-period below 300 ns or above 60 us at the stated system clock period.

The controller has four states. ST_IDLE waits for a request; taking one is transition T_ACCEPT into ST_LOW. ST_LOW holds the serial clock low for one half-period; T_RISE raises the clock and moves to ST_HIGH. ST_HIGH holds it high; T_FALL_NEXT lowers it and returns to ST_LOW when more bits are due. T_FALL_LAST lowers it on the final bit, releases chip select, strobes the result and enters ST_GAP. ST_GAP holds busy for one more half-period; T_RELEASE then returns to ST_IDLE.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock and data-out are low, and busy, result_valid and mismatch are low.
- R2: The serial data bits seen at the first rising clock edges of a read are, in order: 1 (start), the single-ended flag, channel bit 0, then the remaining channel bits from the most significant (bit 2) down to bit 1.
- R3: The outgoing data bit changes only while the serial clock is low, so it is stable at and throughout every high phase.
- R4: Every high phase and every low phase of the serial clock, including the first low phase after chip select falls, lasts exactly HALF_CYC system cycles (50% duty).
- R5: The converter bit sampled at the rising edge right after the last address bit is the settling bit and has no effect on the result.
- R6: The eight bits sampled at the next rising edges form the result, most significant bit first, and the result appears on `result` with the valid strobe.
- R7: A read without echo spans 14 serial clock cycles; a read with echo spans 21. Chip select rises on the falling edge that ends the last cycle, and the serial clock is never high while chip select is high.
- R8: With echo enabled, the seven echoed bits (result bits 1 up to 7, bit 0 being shared) are compared with the first copy, and any difference raises mismatch in the valid cycle. Without echo, mismatch stays low. mismatch is never high outside a valid cycle.
- R9: result_valid is a one-cycle pulse in the cycle chip select rises, and `result` holds its value afterwards.
- R10: busy is high from the cycle after a request is accepted until HALF_CYC cycles after the valid pulse (busy is high for exactly HALF_CYC valid-or-later samples). busy is high whenever chip select is low, and requests seen while busy start nothing.
- R11: Chip select stays high for at least HALF_CYC system cycles between two reads, even when a request is held high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a read (taken only when not busy) |
| req_chan | input | SEL_W+1 | Channel number |
| req_single | input | 1 | 1 = single-ended, 0 = differential |
| req_echo | input | 1 | Collect and compare the LSB-first echo |
| busy | output | 1 | Read or guard interval in progress |
| result | output | DATA_W | Last conversion result |
| result_valid | output | 1 | One-cycle strobe for a new result |
| mismatch | output | 1 | Echo disagreed with first copy (with strobe) |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_di | output | 1 | Serial data to converter |
| adc_do | input | 1 | Serial data from converter |

## Verification
Two events can fall in the same cycle. The final falling clock edge releases chip select, strobes the result and evaluates the echo comparison all together. A request may also be pending while that release and the following guard interval are in progress. The bench holds `req` high straight across the strobe of one read. It then judges three things: that chip select was sampled high in the very strobe cycle, that mismatch reflects only the echo bits deliberately corrupted by the converter model, and that the next read begins only after at least a guard half-period of chip select high.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } rd_state_t;

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int HALF_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == CNT_LAST);

endmodule

// File: rtl/adc_rd_addr.sv
module adc_rd_addr #(
    parameter int SEL_W = 2
) (
    input  logic [SEL_W:0]   chan,
    input  logic             single,
    output logic [SEL_W+2:0] bits
);
    // bits[k] is driven during serial clock cycle k
    assign bits[0] = 1'b1;
    assign bits[1] = single;
    assign bits[2] = chan[0];

    generate
        for (genvar i = 0; i < SEL_W; i++) begin : g_sel
            assign bits[3+i] = chan[SEL_W-i];
        end
    endgenerate

endmodule

// File: rtl/adc_rd_collect.sv
module adc_rd_collect #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              samp_data,
    input  logic              samp_echo,
    input  logic              sdo,
    output logic [DATA_W-1:0] data,
    output logic              echo_ok
);
    logic [DATA_W-1:0] msb_sr;
    logic [DATA_W-2:0] echo_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msb_sr  <= '0;
            echo_sr <= '0;
        end else if (clr) begin
            msb_sr  <= '0;
            echo_sr <= '0;
        end else begin
            if (samp_data) begin
                msb_sr <= {msb_sr[DATA_W-2:0], sdo};
            end
            if (samp_echo) begin
                echo_sr <= {sdo, echo_sr[DATA_W-2:1]};
            end
        end
    end

    assign data    = msb_sr;
    assign echo_ok = (echo_sr == msb_sr[DATA_W-1:1]);

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_rd_pkg::*;
#(
    parameter int SYS_CLK_NS = 10,
    parameter int HALF_CYC   = 32,
    parameter int SEL_W      = 2,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [SEL_W:0]    req_chan,
    input  logic              req_single,
    input  logic              req_echo,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              mismatch,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_di,
    input  logic              adc_do
);
    localparam int N_ADDR  = SEL_W + 3;
    localparam int N_SHORT = N_ADDR + 1 + DATA_W;
    localparam int N_LONG  = N_SHORT + DATA_W - 1;
    localparam int IDX_W   = $clog2(N_LONG + 1);
    localparam int HALF_NS = HALF_CYC * SYS_CLK_NS;

    localparam logic [IDX_W-1:0] IDX_SETTLE    = IDX_W'(N_ADDR);
    localparam logic [IDX_W-1:0] IDX_DATA_LAST = IDX_W'(N_ADDR + DATA_W);
    localparam logic [IDX_W-1:0] IDX_END_SHORT = IDX_W'(N_SHORT - 1);
    localparam logic [IDX_W-1:0] IDX_END_LONG  = IDX_W'(N_LONG - 1);

    generate
        if (HALF_NS < 300 || HALF_NS > 60000) begin : g_bad_divider
            $error("serial clock half-period out of the 300 ns .. 60 us range");
        end
    endgenerate

    rd_state_t state_q, state_d;

    logic              tmr_clr, tmr_done;
    logic [N_ADDR-1:0] addr_w, addr_sr;
    logic [IDX_W-1:0]  bit_idx;
    logic              echo_q;
    logic              last_bit;
    logic              rise_now;
    logic              samp_data, samp_echo;
    logic [DATA_W-1:0] data_w;
    logic              echo_ok;
    logic              accept;

    adc_rd_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .done  (tmr_done)
    );

    adc_rd_addr #(.SEL_W(SEL_W)) u_addr (
        .chan   (req_chan),
        .single (req_single),
        .bits   (addr_w)
    );

    adc_rd_collect #(.DATA_W(DATA_W)) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .samp_data (samp_data),
        .samp_echo (samp_echo),
        .sdo       (adc_do),
        .data      (data_w),
        .echo_ok   (echo_ok)
    );

    assign accept    = (state_q == ST_IDLE) && req;
    assign tmr_clr   = (state_q == ST_IDLE) || tmr_done;
    assign last_bit  = (bit_idx == (echo_q ? IDX_END_LONG : IDX_END_SHORT));
    assign rise_now  = (state_q == ST_LOW) && tmr_done;
    assign samp_data = rise_now && (bit_idx > IDX_SETTLE) && (bit_idx <= IDX_DATA_LAST);
    assign samp_echo = rise_now && (bit_idx > IDX_DATA_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req)      state_d = ST_LOW;                       // T_ACCEPT
            ST_LOW:  if (tmr_done) state_d = ST_HIGH;                      // T_RISE
            ST_HIGH: if (tmr_done) state_d = last_bit ? ST_GAP : ST_LOW;   // T_FALL_LAST / T_FALL_NEXT
            ST_GAP:  if (tmr_done) state_d = ST_IDLE;                      // T_RELEASE
            default: state_d = ST_IDLE;
        endcase
    end

    // transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sr <= '0;
            bit_idx <= '0;
            echo_q  <= 1'b0;
        end else if (accept) begin
            addr_sr <= addr_w;
            bit_idx <= '0;
            echo_q  <= req_echo;
        end else if ((state_q == ST_HIGH) && tmr_done && !last_bit) begin
            addr_sr <= addr_sr >> 1;
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_cs_n     <= 1'b1;
            adc_sclk     <= 1'b0;
            adc_di       <= 1'b0;
            busy         <= 1'b0;
            result       <= '0;
            result_valid <= 1'b0;
            mismatch     <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            mismatch     <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        adc_cs_n <= 1'b0;
                        adc_di   <= addr_w[0];
                        busy     <= 1'b1;
                    end
                end
                ST_LOW: begin
                    if (tmr_done) begin
                        adc_sclk <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (tmr_done) begin
                        adc_sclk <= 1'b0;
                        if (last_bit) begin
                            adc_cs_n     <= 1'b1;
                            adc_di       <= 1'b0;
                            result       <= data_w;
                            result_valid <= 1'b1;
                            mismatch     <= echo_q && !echo_ok;
                        end else begin
                            adc_di <= addr_sr[1];
                        end
                    end
                end
                ST_GAP: begin
                    if (tmr_done) begin
                        busy <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker #(
    parameter int HALF_CYC = 32
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic result_valid,
    input logic mismatch,
    input logic adc_cs_n,
    input logic adc_sclk,
    input logic adc_di
);
    int unsigned hi_cnt;
    int unsigned lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 0;
            lo_cnt <= 0;
        end else begin
            hi_cnt <= adc_sclk ? hi_cnt + 1 : 0;
            lo_cnt <= (!adc_sclk && !adc_cs_n) ? lo_cnt + 1 : 0;
        end
    end

    // R3
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> $stable(adc_di));

    // R4
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sclk) |-> (hi_cnt == HALF_CYC));

    // R4
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_sclk) |-> (lo_cnt == HALF_CYC));

    // R7
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> !adc_cs_n);

    // R8
    mismatch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |-> result_valid);

    // R9
    valid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(adc_cs_n));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R10
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_cs_n |-> busy);

endmodule

bind adc_serial_reader adc_rd_checker #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .result_valid (result_valid),
    .mismatch     (mismatch),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .adc_di       (adc_di)
);

// File: tb/adc_serial_reader_bench.sv
module adc_serial_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H          = 32;
    localparam int SEL_W      = 2;
    localparam int NA         = SEL_W + 3;
    localparam int N_SHORT    = NA + 9;
    localparam int N_LONG     = NA + 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic [2:0] req_chan = '0;
    logic       req_single = 1'b0;
    logic       req_echo = 1'b0;
    logic       busy;
    logic [7:0] result;
    logic       result_valid;
    logic       mismatch;
    logic       adc_cs_n;
    logic       adc_sclk;
    logic       adc_di;
    logic       adc_do = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_serial_reader #(
        .SYS_CLK_NS (CLK_PERIOD),
        .HALF_CYC   (H),
        .SEL_W      (SEL_W),
        .DATA_W     (8)
    ) u_adc_serial_reader (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .req_chan     (req_chan),
        .req_single   (req_single),
        .req_echo     (req_echo),
        .busy         (busy),
        .result       (result),
        .result_valid (result_valid),
        .mismatch     (mismatch),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .adc_di       (adc_di),
        .adc_do       (adc_do)
    );

    // converter model
    logic [7:0]    dev_val = '0;
    logic          dev_settle = 1'b0;
    logic [7:0]    dev_corrupt = '0;
    logic [NA-1:0] di_cap = '0;
    int            rise_cnt = 0;
    int            fall_cnt = 0;
    int            cs_falls = 0;
    int            width_bad = 0;
    int            widths_seen = 0;
    time           t_rise = 0;
    time           t_fall = 0;

    function automatic logic dev_bit(int k);
        if (k == NA) return dev_settle;
        if (k > NA && k <= NA + 8) return dev_val[7 - (k - NA - 1)];
        if (k > NA + 8 && k <= NA + 15) return dev_val[k - NA - 8] ^ dev_corrupt[k - NA - 8];
        return 1'b0;
    endfunction

    always @(negedge adc_cs_n) begin
        rise_cnt = 0;
        fall_cnt = 0;
        cs_falls++;
        t_fall = $time;
    end

    always @(posedge adc_sclk) begin
        if ($time - t_fall != H * CLK_PERIOD) width_bad++;
        widths_seen++;
        if (rise_cnt < NA) di_cap[rise_cnt] = adc_di;
        rise_cnt++;
        t_rise = $time;
    end

    always @(negedge adc_sclk) begin
        if ($time - t_rise != H * CLK_PERIOD) width_bad++;
        widths_seen++;
        t_fall = $time;
        fall_cnt++;
        adc_do <= dev_bit(fall_cnt);
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic logic [NA-1:0] exp_addr(logic [2:0] ch, logic single);
        return {ch[1], ch[2], ch[0], single, 1'b1};
    endfunction

    task automatic wait_valid(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (result_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic issue(input logic [2:0] ch, input logic single, input logic echo);
        @(negedge clk);
        req_chan   = ch;
        req_single = single;
        req_echo   = echo;
        req        = 1'b1;
        @(negedge clk);
        req        = 1'b0;
    endtask

    task automatic run_read(input logic [2:0] ch, input logic single, input logic echo,
                            input logic [7:0] val, input logic settle,
                            input logic [7:0] corrupt, input bit exp_mis);
        bit seen;
        dev_val     = val;
        dev_settle  = settle;
        dev_corrupt = corrupt;
        issue(ch, single, echo);
        wait_valid(seen);
        chk(seen, "R9", "valid seen", seen, 1);
        chk(adc_cs_n == 1'b1, "R9", "cs high in valid cycle", adc_cs_n, 1);
        chk(result == val, "R6", "result (settle bit ignored per R5)", result, val);
        chk(mismatch == exp_mis, "R8", "mismatch", mismatch, exp_mis);
        chk(rise_cnt == (echo ? N_LONG : N_SHORT), "R7", "clock count", rise_cnt,
            echo ? N_LONG : N_SHORT);
        chk(di_cap == exp_addr(ch, single), "R2", "address bits", di_cap, exp_addr(ch, single));
        @(negedge clk);
        chk(!result_valid, "R9", "valid one cycle", result_valid, 0);
        chk(result == val, "R9", "result held", result, val);
        while (busy) @(negedge clk);
    endtask

    task automatic test_reset();
        chk(adc_cs_n == 1'b1, "R1", "cs_n", adc_cs_n, 1);
        chk(adc_sclk == 1'b0, "R1", "sclk", adc_sclk, 0);
        chk(adc_di == 1'b0, "R1", "di", adc_di, 0);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(result_valid == 1'b0 && mismatch == 1'b0, "R1", "strobes",
            {result_valid, mismatch}, 0);
    endtask

    task automatic test_plain();
        run_read(3'd0, 1'b1, 1'b0, 8'hA5, 1'b1, 8'h00, 1'b0);
        run_read(3'd5, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00, 1'b0);
        run_read(3'd6, 1'b1, 1'b0, 8'hFF, 1'b0, 8'h00, 1'b0);
        run_read(3'd3, 1'b0, 1'b0, 8'h5A, 1'b1, 8'h00, 1'b0);
    endtask

    task automatic test_echo();
        run_read(3'd7, 1'b1, 1'b1, 8'h3C, 1'b1, 8'h00, 1'b0);
        run_read(3'd1, 1'b0, 1'b1, 8'h81, 1'b0, 8'h00, 1'b0);
        // corrupt echo bit 7 then bit 1 (R8)
        run_read(3'd2, 1'b1, 1'b1, 8'hC3, 1'b0, 8'h80, 1'b1);
        run_read(3'd4, 1'b1, 1'b1, 8'h00, 1'b1, 8'h02, 1'b1);
        // a corrupted echo is ignored without echo enabled (R8)
        run_read(3'd4, 1'b1, 1'b0, 8'h66, 1'b0, 8'hFE, 1'b0);
    endtask

    task automatic test_busy();
        bit seen;
        int start_falls;
        int gap;
        dev_val = 8'h96; dev_settle = 1'b1; dev_corrupt = '0;
        start_falls = cs_falls;
        issue(3'd1, 1'b1, 1'b0);
        repeat (100) @(negedge clk);
        chk(busy == 1'b1, "R10", "busy mid read", busy, 1);
        issue(3'd6, 1'b0, 1'b1);
        wait_valid(seen);
        chk(cs_falls - start_falls == 1, "R10", "one frame only", cs_falls - start_falls, 1);
        chk(di_cap == exp_addr(3'd1, 1'b1), "R10", "first address kept", di_cap,
            exp_addr(3'd1, 1'b1));
        chk(rise_cnt == N_SHORT, "R10", "first echo setting kept", rise_cnt, N_SHORT);
        gap = 0;
        while (busy && gap < 1000) begin
            gap++;
            @(negedge clk);
        end
        chk(gap == H, "R10", "busy after valid", gap, H);
    endtask

    task automatic test_back_to_back();
        bit seen;
        int hi;
        dev_val = 8'h42; dev_settle = 1'b0; dev_corrupt = '0;
        @(negedge clk);
        req_chan = 3'd2; req_single = 1'b1; req_echo = 1'b0; req = 1'b1;
        wait_valid(seen);
        hi = 0;
        while (adc_cs_n && hi < 1000) begin
            hi++;
            @(negedge clk);
        end
        req = 1'b0;
        chk(hi >= H && hi < 1000, "R11", "cs high gap", hi, H);
        wait_valid(seen);
        chk(seen && result == 8'h42, "R11", "second read", result, 8'h42);
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_plain();
        test_echo();
        test_busy();
        test_back_to_back();
        chk(width_bad == 0 && widths_seen > 0, "R4", "clock phase widths", width_bad, 0);
        summary();
        $finish;
    end

endmodule